// File: doc/BRIEF.md
# LCD Clock Divider and Frame Interrupt Unit

This block generates the timing base for an LCD controller. Two clock sources arrive as single-cycle enables on one system clock: a fast clock and a low-speed oscillator. A control register picks one of them. When the fast clock is picked, a power-of-two prescaler divides it by a ratio chosen with a three-bit code. The selected and divided ticks come out as `lcd_clk_en`. A frame counter counts these ticks and emits `frame_strobe` once every `FRAME_TICKS` ticks.

Each frame strobe sets a sticky frame flag. Software clears the flag by writing a 1 to it. The interrupt request is raised while the flag is set and the mask bit enables it. Software reaches the three registers over a small 8-bit port. Writes take effect on the clock edge. Reads are combinational while `reg_rd` is high. None of the pins carries a data stream, so there is no valid/ready handshake. Every strobe and tick is a plain single-cycle level.

Top module: `lcd_clkfrm_unit`

## Requirements
- R1: After reset, the clock control register (address 0) reads 0x02: source bit 1, ratio code 0 and enable bit 0. The mask register (address 1) and the flag register (address 2) read 0x00.
- R2: The clock control register stores write-data bit 0 as the enable, bit 1 as the source select (1 = low-speed oscillator, 0 = fast clock) and bits 4..2 as the ratio code. Bits 7..5 always read 0.
- R3: With the enable at 1 and the fast clock selected, `lcd_clk_en` pulses once per 2^(5+code) fast ticks for codes 0 to 4, which gives divide-by-32 up to divide-by-512.
- R4: Ratio codes 5, 6 and 7 divide the fast clock by 32.
- R5: With the enable at 1 and the low-speed oscillator selected, `lcd_clk_en` equals `slow_tick` in every cycle, and the ratio code has no effect.
- R6: While the enable bit is 0, `lcd_clk_en` and `frame_strobe` stay low and the frame flag is not set.
- R7: `frame_strobe` is high together with every `FRAME_TICKS`-th `lcd_clk_en` pulse after enabling, and at no other time.
- R8: The frame flag (address 2, bit 0) reads 1 from the cycle after a frame strobe onward.
- R9: `irq` is high exactly when the frame flag and the mask bit (address 1, bit 0) are both 1.
- R10: Writing address 2 with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged. When a frame strobe falls in the same cycle as a clear, the flag ends up set.
- R11: Reading address 3 returns 0x00. Bits 7..1 of the mask and flag registers read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | One-cycle enable of the fast clock source |
| slow_tick | input | 1 | One-cycle enable of the low-speed oscillator |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, 0 otherwise |
| lcd_clk_en | output | 1 | Divided LCD clock enable pulse |
| frame_strobe | output | 1 | One-cycle pulse per frame |
| irq | output | 1 | Frame interrupt request |

## Verification
The bound checker watches, on every cycle:
- the silence of both strobes while the clock is disabled;
- the pass-through of the slow source;
- the coincidence of every frame strobe with a tick;
- the flag's set, hold and clear rules, including set-wins;
- that a new interrupt request only follows a frame strobe or the mask being set.

Only the bench's scenarios can show:
- the exact spacing of divided ticks for each ratio code, including the reserved codes;
- the spacing under gapped fast-clock patterns;
- the reset values and the masking of the register fields.

// File: rtl/lcdcf_pkg.sv
`timescale 1ns/1ps
package lcdcf_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CLKCTL = 2'd0,
    ADR_MASK   = 2'd1,
    ADR_FLAG   = 2'd2
  } lcdcf_addr_e;

  typedef struct packed {
    logic [CODE_W-1:0] div_code;
    logic              src_slow;
    logic              clk_on;
  } clkctl_t;

  localparam clkctl_t CLKCTL_RST = '{div_code: '0, src_slow: 1'b1, clk_on: 1'b0};
endpackage

// File: rtl/lcdcf_regs.sv
`timescale 1ns/1ps
module lcdcf_regs
  import lcdcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              flag_q,
  output clkctl_t           ctl_q,
  output logic              mask_q,
  output logic              flag_clr,
  output logic [REG_W-1:0]  rdata
);
  localparam int CTL_W = $bits(clkctl_t);

  lcdcf_addr_e sel;
  assign sel = lcdcf_addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CLKCTL_RST;
      mask_q <= 1'b0;
    end else if (wr) begin
      if (sel == ADR_CLKCTL) ctl_q  <= clkctl_t'(wdata[CTL_W-1:0]);
      if (sel == ADR_MASK)   mask_q <= wdata[0];
    end
  end

  // Clear request: write-one to bit 0 of the flag register.
  assign flag_clr = wr && (sel == ADR_FLAG) && wdata[0];

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        ADR_CLKCTL: rdata = {{(REG_W-CTL_W){1'b0}}, ctl_q};
        ADR_MASK:   rdata = {{(REG_W-1){1'b0}}, mask_q};
        ADR_FLAG:   rdata = {{(REG_W-1){1'b0}}, flag_q};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcdcf_divider.sv
`timescale 1ns/1ps
module lcdcf_divider
  import lcdcf_pkg::*;
#(
  parameter int BASE_LOG2 = 5,
  parameter int NUM_CODES = 5,
  localparam int CNT_W    = BASE_LOG2 + NUM_CODES - 1,
  localparam int CODES    = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              clk_on,
  input  logic              src_slow,
  input  logic [CODE_W-1:0] div_code,
  output logic              lcd_tick
);
  logic [CNT_W-1:0] term_tbl [CODES];

  // Terminal count per code; codes past NUM_CODES fall back to the base ratio.
  for (genvar g = 0; g < CODES; g++) begin : g_term
    localparam int LOG = (g < NUM_CODES) ? BASE_LOG2 + g : BASE_LOG2;
    assign term_tbl[g] = CNT_W'((1 << LOG) - 1);
  end

  logic [CNT_W-1:0] cnt_q;
  logic             at_term;
  logic             run_fast;

  assign run_fast = clk_on && !src_slow;
  assign at_term  = cnt_q >= term_tbl[div_code];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run_fast) cnt_q <= '0;
    else if (fast_tick) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
  end

  assign lcd_tick = (run_fast && fast_tick && at_term) ||
                    (clk_on && src_slow && slow_tick);
endmodule

// File: rtl/lcdcf_frame.sv
`timescale 1ns/1ps
module lcdcf_frame #(
  parameter int FRAME_TICKS = 64,
  localparam int FW = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_on,
  input  logic lcd_tick,
  input  logic flag_clr,
  output logic frame_strobe,
  output logic flag_q
);
  logic [FW-1:0] fcnt_q;
  logic          last;

  assign last         = fcnt_q == FW'(FRAME_TICKS - 1);
  assign frame_strobe = lcd_tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fcnt_q <= '0;
    else if (!clk_on)  fcnt_q <= '0;
    else if (lcd_tick) fcnt_q <= last ? '0 : fcnt_q + 1'b1;
  end

  // Sticky flag; a frame event outranks a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (frame_strobe) flag_q <= 1'b1;
    else if (flag_clr)     flag_q <= 1'b0;
  end
endmodule

// File: rtl/lcd_clkfrm_unit.sv
`timescale 1ns/1ps
module lcd_clkfrm_unit
  import lcdcf_pkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int BASE_LOG2   = 5,
  parameter int NUM_CODES   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              lcd_clk_en,
  output logic              frame_strobe,
  output logic              irq
);
  clkctl_t ctl_q;
  logic    mask_q;
  logic    flag_q;
  logic    flag_clr;
  logic    ctl_on;
  logic    ctl_slow;

  assign ctl_on   = ctl_q.clk_on;
  assign ctl_slow = ctl_q.src_slow;

  lcdcf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .flag_q   (flag_q),
    .ctl_q    (ctl_q),
    .mask_q   (mask_q),
    .flag_clr (flag_clr),
    .rdata    (reg_rdata)
  );

  lcdcf_divider #(
    .BASE_LOG2 (BASE_LOG2),
    .NUM_CODES (NUM_CODES)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .clk_on    (ctl_on),
    .src_slow  (ctl_slow),
    .div_code  (ctl_q.div_code),
    .lcd_tick  (lcd_clk_en)
  );

  lcdcf_frame #(
    .FRAME_TICKS (FRAME_TICKS)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_on       (ctl_on),
    .lcd_tick     (lcd_clk_en),
    .flag_clr     (flag_clr),
    .frame_strobe (frame_strobe),
    .flag_q       (flag_q)
  );

  assign irq = flag_q && mask_q;
endmodule

// File: rtl/lcdcf_checker.sv
`timescale 1ns/1ps
module lcdcf_checker (
  input logic clk,
  input logic rst_n,
  input logic clk_on,
  input logic src_slow,
  input logic slow_tick,
  input logic lcd_clk_en,
  input logic frame_strobe,
  input logic flag_q,
  input logic flag_clr,
  input logic mask_q,
  input logic irq
);
  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |-> (!lcd_clk_en && !frame_strobe));

  assert_slow_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_on && src_slow) |-> (lcd_clk_en == slow_tick));

  assert_frame_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> lcd_clk_en);

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> flag_q);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_flag_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !frame_strobe) |=> !flag_q);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(frame_strobe) || $rose(mask_q)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |-> !irq);
endmodule

bind lcd_clkfrm_unit lcdcf_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_on       (ctl_on),
  .src_slow     (ctl_slow),
  .slow_tick    (slow_tick),
  .lcd_clk_en   (lcd_clk_en),
  .frame_strobe (frame_strobe),
  .flag_q       (flag_q),
  .flag_clr     (flag_clr),
  .mask_q       (mask_q),
  .irq          (irq)
);

// File: tb/lcd_clkfrm_unit_test.sv
`timescale 1ns/1ps
module lcd_clkfrm_unit_test;
  localparam int FT = 4;

  logic       clk = 1'b0, rst_n = 1'b0, fast_tick = 1'b0, slow_tick = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  wire  [7:0] reg_rdata;
  wire        lcd_clk_en, frame_strobe, irq;

  lcd_clkfrm_unit #(.FRAME_TICKS(FT)) uut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .lcd_clk_en(lcd_clk_en), .frame_strobe(frame_strobe), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int gap_q[$];
  bit sh_en = 1'b0, sh_slow = 1'b1, resync = 1'b1;
  int sh_code = 0, fr_cnt = 0, cyc = 0, last = 0, tick_period = 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fast-clock pattern: every cycle, or every other cycle.
  initial forever begin
    @(posedge clk); #1;
    fast_tick = (tick_period == 1) ? 1'b1 : ~fast_tick;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 2'd0) begin
      sh_en = d[0]; sh_slow = d[1]; sh_code = int'(d[4:2]);
      if (!d[0]) begin resync = 1'b1; fr_cnt = 0; end
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic slow_pulse();
    @(posedge clk); #1; slow_tick = 1'b1;
    @(posedge clk); #1; slow_tick = 1'b0;
  endtask

  // Driver: configure the fast source and push the expected tick spacing.
  task automatic run_fast(input int code, input int period, input int n);
    int lim;
    lim = (code <= 4) ? (32 << code) : 32;
    tick_period = period;
    repeat (3) @(posedge clk);
    wr(2'd0, 8'((code << 2) | 1));
    for (int i = 0; i < n; i++) gap_q.push_back(lim * period);
    while (gap_q.size() > 0) @(negedge clk);
    wr(2'd0, 8'(code << 2));
    repeat (3) @(posedge clk);
  endtask

  // Monitor / scoreboard.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      cyc++;
      if (!sh_en) begin
        if (lcd_clk_en || frame_strobe)
          check(1'b0, "R6 strobe while disabled", 1, 0);
      end else begin
        if (sh_slow)
          check(lcd_clk_en == slow_tick, "R5 slow pass-through", int'(lcd_clk_en), int'(slow_tick));
        if (lcd_clk_en) begin
          if (!sh_slow) begin
            if (!resync && gap_q.size() > 0) begin
              int e;
              e = gap_q.pop_front();
              check(cyc - last == e, (sh_code > 4) ? "R4 reserved-code spacing" : "R3 divided spacing",
                    cyc - last, e);
            end
            last = cyc;
            resync = 1'b0;
          end
          check(frame_strobe == (fr_cnt == FT - 1), "R7 frame strobe position",
                int'(frame_strobe), int'(fr_cnt == FT - 1));
          fr_cnt = (fr_cnt == FT - 1) ? 0 : fr_cnt + 1;
        end else if (frame_strobe) begin
          check(1'b0, "R7 strobe without tick", 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(2'd0, v); check(v == 8'h02, "R1 clkctl reset", v, 8'h02);
    rd(2'd1, v); check(v == 8'h00, "R1 mask reset", v, 0);
    rd(2'd2, v); check(v == 8'h00, "R1 flag reset", v, 0);
    rd(2'd3, v); check(v == 8'h00, "R11 unmapped read", v, 0);

    wr(2'd0, 8'hFC); rd(2'd0, v); check(v == 8'h1C, "R2 field storage", v, 8'h1C);
    wr(2'd0, 8'hE2); rd(2'd0, v); check(v == 8'h02, "R2 reserved bits read 0", v, 8'h02);
    wr(2'd1, 8'hFE); rd(2'd1, v); check(v == 8'h00, "R11 mask upper bits", v, 0);
    wr(2'd1, 8'hFF); rd(2'd1, v); check(v == 8'h01, "R11 mask bit0", v, 1);
    wr(2'd1, 8'h00);

    run_fast(0, 1, 3);
    run_fast(1, 1, 2);
    run_fast(2, 1, 2);
    run_fast(3, 1, 2);
    run_fast(4, 1, 2);
    run_fast(5, 1, 2);
    run_fast(7, 1, 2);
    run_fast(0, 2, 3);
    run_fast(2, 2, 2);
    tick_period = 1;

    rd(2'd2, v); check(v == 8'h01, "R8 flag set by fast frames", v, 1);
    wr(2'd2, 8'hFF); rd(2'd2, v); check(v == 8'h00, "R10 write-one clears", v, 0);

    // Slow source, non-zero code that must be ignored.
    wr(2'd0, 8'h13);
    repeat (FT) slow_pulse();
    rd(2'd2, v); check(v == 8'h01, "R8 flag after slow frame", v, 1);
    check(irq == 1'b0, "R9 irq masked", int'(irq), 0);
    wr(2'd1, 8'h01);
    check(irq == 1'b1, "R9 irq asserted", int'(irq), 1);
    wr(2'd2, 8'hFE); rd(2'd2, v); check(v == 8'h01, "R10 write-zero keeps flag", v, 1);
    check(irq == 1'b1, "R9 irq held", int'(irq), 1);
    wr(2'd2, 8'h01); rd(2'd2, v); check(v == 8'h00, "R10 clear", v, 0);
    check(irq == 1'b0, "R9 irq dropped", int'(irq), 0);

    // Frame event coincides with a clear: set wins.
    repeat (FT - 1) slow_pulse();
    @(posedge clk); #1;
    slow_tick = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(posedge clk); #1;
    slow_tick = 1'b0; reg_wr = 1'b0;
    rd(2'd2, v); check(v == 8'h01, "R10 set wins over clear", v, 1);
    check(irq == 1'b1, "R9 irq after set-wins", int'(irq), 1);

    // Disabled: slow ticks must produce nothing.
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h01);
    repeat (2 * FT) slow_pulse();
    rd(2'd2, v); check(v == 8'h00, "R6 no frame while disabled", v, 0);
    check(irq == 1'b0, "R6 no irq while disabled", int'(irq), 0);

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule